// File: doc/BRIEF.md
# Indirect Colormap Palette Port

This block holds a 256-entry colour lookup table and presents it to software through a narrow 32-bit register slave. Software first writes an entry number to an index register. It then streams colour components into a data register, one byte per write. The block collects red, then green, then blue. It writes the whole entry on the blue component and moves to the next entry by itself, so any run of consecutive entries can be reloaded without touching the rest of the table.

The same index register also addresses a small bank of control bytes. Control byte 6 drives the two cursor-enable outputs. Software changes it by reading the byte, changing the bits it wants, and writing the whole byte back.

A separate pixel port looks up the table for scanout with one cycle of registered latency. It never waits on register traffic.

Top module: `palette_port`

## Requirements
- R1: While reset is asserted and after its release, the index is 0, the component phase is red, all control bytes are 0, `cursor_en` is 0, `reg_rdata` is 0 and `pix_rgb` is 0.
- R2: A write with `reg_sel`=0 loads the index from `reg_wdata[31:24]`, ignores bits 23:0, and returns the phase to red.
- R3: Writes with `reg_sel`=1 take one component from `reg_wdata[31:24]` in the order red, green, blue. The table entry changes only on the blue write, to {red,green,blue} with red in bits 23:16.
- R4: After a blue write the index increments by one, and 255 wraps to 0.
- R5: An index write between components drops the components gathered so far, and the next data write is taken as red.
- R6: Reloading a run of entries leaves every entry outside the run unchanged.
- R7: `pix_rgb` shows the entry selected by `pix_idx` one clock edge after it is presented. If the same edge writes that entry, the old content is returned and the new content appears one edge later.
- R8: A write with `reg_sel`=2 stores `reg_wdata[31:24]` into control byte number `index` when the index is below 8, and is ignored otherwise. It changes neither the index nor the phase.
- R9: `cursor_en` equals bits 1:0 of control byte 6. The other bits of that byte are kept exactly as written.
- R10: A read strobe loads `reg_rdata` one edge later: select 0 gives {index,24'h0}, select 2 gives {control byte at index (0 if index is 8 or above),24'h0}, and selects 1 and 3 give 0. Without a strobe, `reg_rdata` holds its value. Writes with select 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 index, 1 colour, 2 control, 3 reserved |
| reg_wdata | input | 32 | Write data; only bits 31:24 are used |
| reg_rdata | output | 32 | Registered read data |
| pix_idx | input | 8 | Pixel value for lookup |
| pix_rgb | output | 24 | Looked-up colour, red in bits 23:16 |
| cursor_en | output | 2 | Cursor enables from control byte 6 |

## Verification
Results are due at different edges:
- Index, phase and control updates are visible at the edge that takes the write.
- A committed entry is visible on `pix_rgb` one edge after `pix_idx` points at it.
- `reg_rdata` is valid one edge after the read strobe.

The bench drives every input just after a falling edge and samples on the next falling edge, so exactly one rising edge lies between stimulus and check. The same-edge write and lookup case is checked at both the first and the second edge to confirm the one-cycle delay of the new value.

// File: rtl/palette_pkg.sv
package palette_pkg;
  typedef enum logic [1:0] {
    SEL_INDEX  = 2'd0,
    SEL_COLOUR = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_RSVD   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2,
    PH_BAD = 2'd3
  } phase_e;
endpackage

// File: rtl/pal_seq.sv
module pal_seq
  import palette_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [CW-1:0]    wbyte,
  output logic [IDX_W-1:0] idx_q,
  output phase_e           phase_q,
  output logic             commit,
  output logic [IDX_W-1:0] commit_idx,
  output logic [3*CW-1:0]  commit_rgb
);
  logic [IDX_W-1:0] idx_d;
  phase_e           phase_d;
  logic [CW-1:0]    red_q, grn_q;
  logic             idx_en, phase_en, red_en, grn_en;
  logic             load_idx, col_wr;

  assign load_idx = wr_en && (sel == SEL_INDEX);
  assign col_wr   = wr_en && (sel == SEL_COLOUR);

  always_comb begin
    idx_d    = idx_q;
    phase_d  = phase_q;
    idx_en   = 1'b0;
    phase_en = 1'b0;
    red_en   = 1'b0;
    grn_en   = 1'b0;
    commit   = 1'b0;
    if (load_idx) begin
      idx_d    = wbyte[CW-1 -: IDX_W];
      phase_d  = PH_RED;
      idx_en   = 1'b1;
      phase_en = 1'b1;
    end else if (col_wr) begin
      phase_en = 1'b1;
      unique case (phase_q)
        PH_RED: begin
          red_en  = 1'b1;
          phase_d = PH_GRN;
        end
        PH_GRN: begin
          grn_en  = 1'b1;
          phase_d = PH_BLU;
        end
        default: begin
          commit  = 1'b1;
          phase_d = PH_RED;
          idx_d   = idx_q + IDX_W'(1);
          idx_en  = 1'b1;
        end
      endcase
    end
  end

  assign commit_idx = idx_q;
  assign commit_rgb = {red_q, grn_q, wbyte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
    end else begin
      if (idx_en)   idx_q   <= idx_d;
      if (phase_en) phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      red_q <= '0;
      grn_q <= '0;
    end else begin
      if (red_en) red_q <= wbyte;
      if (grn_en) grn_q <= wbyte;
    end
  end
endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int IDX_W = 8,
  parameter int DW    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[raddr];
  end
endmodule

// File: rtl/pal_ctrl.sv
module pal_ctrl #(
  parameter int IDX_W       = 8,
  parameter int CW          = 8,
  parameter int NCTRL       = 8,
  parameter int CURSOR_ADDR = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [CW-1:0]    wbyte,
  output logic [CW-1:0]    rd_byte,
  output logic [1:0]       cursor_en
);
  localparam int CAW = (NCTRL > 1) ? $clog2(NCTRL) : 1;

  logic [CW-1:0] ctrl_q [NCTRL];
  logic          hit;
  logic [CAW-1:0] sub;

  assign hit = ((idx >> CAW) == '0);
  assign sub = idx[CAW-1:0];

  for (genvar i = 0; i < NCTRL; i++) begin : g_ctrl
    logic en;
    assign en = wr_en && hit && (sub == CAW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctrl_q[i] <= '0;
      else if (en) ctrl_q[i] <= wbyte;
    end
  end

  assign rd_byte   = hit ? ctrl_q[sub] : '0;
  assign cursor_en = ctrl_q[CURSOR_ADDR][1:0];
endmodule

// File: rtl/palette_port.sv
module palette_port
  import palette_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int IDX_W = 8,
  parameter int CW    = 8,
  parameter int NCTRL = 8,
  parameter int CURSOR_ADDR = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_sel,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic [IDX_W-1:0] pix_idx,
  output logic [3*CW-1:0]  pix_rgb,
  output logic [1:0]       cursor_en
);
  localparam int RGB_W = 3 * CW;

  reg_sel_e         sel;
  logic [CW-1:0]    wbyte;
  logic             unused_low;
  logic [IDX_W-1:0] cur_idx;
  phase_e           cur_phase;
  logic             commit;
  logic [IDX_W-1:0] commit_idx;
  logic [RGB_W-1:0] commit_rgb;
  logic [CW-1:0]    ctrl_byte;
  logic             ctrl_wr;
  logic [BUS_W-1:0] rdata_d;

  assign sel        = reg_sel_e'(reg_sel);
  assign wbyte      = reg_wdata[BUS_W-1 -: CW];
  assign unused_low = ^reg_wdata[BUS_W-CW-1:0];
  assign ctrl_wr    = reg_wr && (sel == SEL_CTRL);

  pal_seq #(.IDX_W(IDX_W), .CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .sel        (sel),
    .wbyte      (wbyte),
    .idx_q      (cur_idx),
    .phase_q    (cur_phase),
    .commit     (commit),
    .commit_idx (commit_idx),
    .commit_rgb (commit_rgb)
  );

  pal_ram #(.IDX_W(IDX_W), .DW(RGB_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (commit),
    .waddr (commit_idx),
    .wdata (commit_rgb),
    .raddr (pix_idx),
    .rdata (pix_rgb)
  );

  pal_ctrl #(.IDX_W(IDX_W), .CW(CW), .NCTRL(NCTRL), .CURSOR_ADDR(CURSOR_ADDR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctrl_wr),
    .idx       (cur_idx),
    .wbyte     (wbyte),
    .rd_byte   (ctrl_byte),
    .cursor_en (cursor_en)
  );

  always_comb begin
    rdata_d = '0;
    unique case (sel)
      SEL_INDEX: rdata_d = {cur_idx, {(BUS_W-IDX_W){1'b0}}};
      SEL_CTRL:  rdata_d = {ctrl_byte, {(BUS_W-CW){1'b0}}};
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rdata_d;
  end
endmodule

// File: rtl/palette_port_chk.sv
module palette_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [1:0]  reg_sel,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic [1:0]  cursor_en,
  input logic [7:0]  cur_idx,
  input logic [1:0]  cur_phase
);
  p_addr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0) |=> (cur_idx == $past(reg_wdata[31:24]) && cur_phase == 2'd0));

  p_phase_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cur_phase != 2'd3);

  p_blue_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd1 && cur_phase == 2'd2) |=>
      (cur_idx == $past(cur_idx) + 8'd1 && cur_phase == 2'd0));

  p_ctrl_noseq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd2) |=>
      (cur_idx == $past(cur_idx) && cur_phase == $past(cur_phase)));

  p_cursor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd2 && cur_idx == 8'd6) |=> (cursor_en == $past(reg_wdata[25:24])));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind palette_port palette_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .cursor_en (cursor_en),
  .cur_idx   (cur_idx),
  .cur_phase (cur_phase)
);

// File: tb/palette_port_tb_top.sv
module palette_port_tb_top;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_rd;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [7:0]  pix_idx;
  logic [23:0] pix_rgb;
  logic [1:0]  cursor_en;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  palette_port dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pix_idx   (pix_idx),
    .pix_rgb   (pix_rgb),
    .cursor_en (cursor_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 32'h00ff_ffff;
  endtask

  task automatic set_idx(input logic [7:0] i);
    wr(2'd0, {i, 24'h5a5a5a});
  endtask

  task automatic put_rgb(input logic [23:0] c);
    wr(2'd1, {c[23:16], 24'h123456});
    wr(2'd1, {c[15:8],  24'habcdef});
    wr(2'd1, {c[7:0],   24'h000000});
  endtask

  task automatic rd(input logic [1:0] s, input string tag, input logic [31:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = s;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic look(input logic [7:0] i, input string tag, input logic [23:0] exp);
    @(negedge clk);
    pix_idx = i;
    @(negedge clk);
    chk(tag, {8'h0, pix_rgb}, {8'h0, exp});
  endtask

  task automatic t_reset;
    chk("R1 cursor_en", {30'h0, cursor_en}, 32'h0);
    chk("R1 reg_rdata", reg_rdata, 32'h0);
    chk("R1 pix_rgb", {8'h0, pix_rgb}, 32'h0);
    rd(2'd0, "R1 index", 32'h0);
    rd(2'd2, "R1 ctrl0", 32'h0);
  endtask

  task automatic t_addr;
    wr(2'd0, 32'ha5_123456);
    rd(2'd0, "R2 index load", 32'ha500_0000);
  endtask

  task automatic t_triplet;
    set_idx(8'h10);
    put_rgb(24'h010203);
    look(8'h10, "R3 first entry", 24'h010203);
    set_idx(8'h10);
    wr(2'd1, 32'h11_000000);
    wr(2'd1, 32'h22_000000);
    look(8'h10, "R3 no commit before blue", 24'h010203);
    wr(2'd1, 32'h33_000000);
    look(8'h10, "R3 commit on blue", 24'h112233);
  endtask

  task automatic t_autoinc;
    set_idx(8'h20);
    put_rgb(24'ha00001);
    put_rgb(24'ha00002);
    put_rgb(24'ha00003);
    look(8'h21, "R4 second entry", 24'ha00002);
    look(8'h22, "R4 third entry", 24'ha00003);
    rd(2'd0, "R4 index after run", 32'h2300_0000);
    set_idx(8'hff);
    put_rgb(24'hfffff0);
    put_rgb(24'h00000f);
    look(8'hff, "R4 entry 255", 24'hfffff0);
    look(8'h00, "R4 wrap entry 0", 24'h00000f);
    rd(2'd0, "R4 index wrapped", 32'h0100_0000);
  endtask

  task automatic t_abort;
    set_idx(8'h30);
    wr(2'd1, 32'hee_000000);
    wr(2'd1, 32'hdd_000000);
    set_idx(8'h30);
    put_rgb(24'h445566);
    look(8'h30, "R5 partial dropped", 24'h445566);
  endtask

  task automatic t_range;
    set_idx(8'h40);
    for (int i = 0; i < 8; i++) put_rgb({16'h4040, 8'(i)});
    set_idx(8'h42);
    for (int i = 2; i < 5; i++) put_rgb({16'h7777, 8'(i)});
    for (int i = 0; i < 8; i++)
      look(8'(8'h40 + i), $sformatf("R6 entry %0d", i),
           (i >= 2 && i < 5) ? {16'h7777, 8'(i)} : {16'h4040, 8'(i)});
  endtask

  task automatic t_latency;
    set_idx(8'h50);
    put_rgb(24'haaaaaa);
    look(8'h40, "R7 setup", 24'h404000);
    set_idx(8'h50);
    wr(2'd1, 32'h01_000000);
    wr(2'd1, 32'h02_000000);
    @(negedge clk);
    pix_idx = 8'h50; reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 32'h03_000000;
    #1 chk("R7 no change before edge", {8'h0, pix_rgb}, 32'h00404000);
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R7 same edge old value", {8'h0, pix_rgb}, 32'h00aaaaaa);
    @(negedge clk);
    chk("R7 new value next edge", {8'h0, pix_rgb}, 32'h00010203);
  endtask

  task automatic t_ctrl;
    set_idx(8'h03);
    wr(2'd2, 32'h5a_000000);
    rd(2'd0, "R8 index kept", 32'h0300_0000);
    rd(2'd2, "R8 ctrl readback", 32'h5a00_0000);
    put_rgb(24'h0c0d0e);
    look(8'h03, "R8 phase kept", 24'h0c0d0e);
    set_idx(8'h09);
    wr(2'd2, 32'h77_000000);
    rd(2'd2, "R8 out of range ignored", 32'h0);
    set_idx(8'h01);
    rd(2'd2, "R8 alias not written", 32'h0);
  endtask

  task automatic t_cursor;
    set_idx(8'h06);
    wr(2'd2, 32'hf0_000000);
    chk("R9 cursor off", {30'h0, cursor_en}, 32'h0);
    rd(2'd2, "R9 read before modify", 32'hf000_0000);
    wr(2'd2, (reg_rdata | 32'h0300_0000));
    chk("R9 cursor on", {30'h0, cursor_en}, 32'h3);
    rd(2'd2, "R9 other bits kept", 32'hf300_0000);
  endtask

  task automatic t_read;
    rd(2'd1, "R10 colour select reads 0", 32'h0);
    set_idx(8'h06);
    rd(2'd0, "R10 index", 32'h0600_0000);
    repeat (3) @(negedge clk);
    chk("R10 hold without strobe", reg_rdata, 32'h0600_0000);
    wr(2'd3, 32'h00_000000);
    rd(2'd3, "R10 reserved reads 0", 32'h0);
    rd(2'd0, "R10 reserved write no index change", 32'h0600_0000);
    chk("R10 reserved write no cursor change", {30'h0, cursor_en}, 32'h3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_sel = 2'd0;
    reg_wdata = 32'h0; pix_idx = 8'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_addr();
    t_triplet();
    t_autoinc();
    t_abort();
    t_range();
    t_latency();
    t_ctrl();
    t_cursor();
    t_read();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule